// File: doc/BRIEF.md
# Flash Command Mode Controller

This block watches the write cycles that a processor issues to a parallel Flash array and keeps track of which operating mode the array is in. It recognises a two-write unlock prefix followed by a command byte, a bare reset command, and the data write that follows a program setup. From these it moves between normal array reads, status/identifier reads, programming, whole-array erase, single-sector erase, a latched error state and a timed recovery state. The array itself is modelled by two pulse inputs: one reports that the running operation has finished, the other reports that it has failed.

Its main job is to handle the reset command correctly in each mode. In a read mode or the error state the command takes effect at once. During a program or whole-array erase it has no effect. During a sector erase it aborts the erase and starts a recovery interval, and a dedicated hardware reset pulse can break into any state. The recovery interval is a parameter counted in clock cycles. It defaults to 25 µs at 125 MHz. While the interval runs, `busy` is high and bus writes are discarded.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode` is 0 (read array), `dq5` is 0 and `busy` is 0. The mode codes are: 0 read array, 1 status/ID read, 2 program, 3 whole-array erase, 4 sector erase, 5 error, 6 recovering. `dq5` is 1 exactly in mode 5 and `busy` is 1 exactly in mode 6.
- R2: In mode 0, the unlock prefix (data AAh at address 555h, then data 55h at address AAAh) followed by a third write with data 90h, 10h or 30h moves `mode` to 1, 3 or 4 respectively. The change is visible after the clock edge that captures the third write. After the prefix, every other data value leaves the mode unchanged.
- R3: In mode 0, the prefix followed by A0h arms a program but leaves `mode` at 0. The next write, whatever its address or data (including F0h), is taken as program data and moves `mode` to 2. An unprefixed A0h arms nothing.
- R4: Data F0h is a reset command when written bare (with no prefix in progress) or as the third write after the prefix. In modes 0 and 1 it gives mode 0. In mode 0 any other bare data value has no effect.
- R5: A write that does not match the next expected unlock cycle (wrong data or wrong address) sends the prefix decoder back to idle and changes no mode. This includes F0h written in the second unlock slot.
- R6: Mode 1 ignores every command except reset, including prefixed 10h and A0h and any bare write.
- R7: A reset command in mode 2 or mode 3 is ignored, and the mode stays the same.
- R8: A reset command in mode 4 gives mode 6 with `busy` high for exactly RECOVER_CYCLES cycles, after which the mode is 0.
- R9: While in mode 6, all writes are discarded and leave no partial prefix behind. After recovery, a bare 90h leaves the mode at 0.
- R10: In modes 2–4, `arr_fault` gives mode 5 with `dq5` set, and `arr_done` gives mode 0. A fault takes priority over a done pulse and over a write in the same cycle. A done pulse takes priority over a write in the same cycle.
- R11: Mode 5 holds through any non-reset command and any array pulse. A reset command (bare or prefixed) returns it to mode 0 and clears `dq5` at the same edge.
- R12: An `hw_rst` pulse takes priority over every other input in the same cycle. It clears the decoder and any armed program. In modes 2, 3, 4 or 6 it (re)starts a full recovery into mode 6. In modes 0, 1 and 5 it gives mode 0 at the next edge.
- R13: `arr_done` and `arr_fault` have no effect in modes 0, 1 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| hw_rst | input | 1 | One-cycle hardware reset pulse that aborts any operation |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| arr_done | input | 1 | Array reports the running operation finished |
| arr_fault | input | 1 | Array reports the running operation failed |
| mode | output | 3 | Current operating mode code (see R1) |
| dq5 | output | 1 | Error flag |
| busy | output | 1 | Recovery interval running, writes discarded |

## Verification
Two events can land on the same edge: a reset command written during a sector erase, and the array's own done or fault pulse for that erase. The bench drives both in one cycle from sector-erase mode and expects the completion report to win. A done pulse must give read mode with no recovery, and a fault must give the error mode with `dq5` set. A hardware reset is also driven together with a done pulse in program mode, and together with a prefixed command write, and the bench expects the reset to win over both.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef enum logic [2:0] {
    MODE_READ         = 3'd0,
    MODE_STATUS_ID    = 3'd1,
    MODE_PROGRAM      = 3'd2,
    MODE_BULK_ERASE   = 3'd3,
    MODE_SECTOR_ERASE = 3'd4,
    MODE_ERROR        = 3'd5,
    MODE_RECOVERING   = 3'd6
  } fmc_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_RESET    = 3'd1,
    CMD_IDREAD   = 3'd2,
    CMD_PROG_ARM = 3'd3,
    CMD_BULK     = 3'd4,
    CMD_SECTOR   = 3'd5
  } fmc_cmd_e;

  typedef enum logic [1:0] {
    UNL_IDLE   = 2'd0,
    UNL_FIRST  = 2'd1,
    UNL_SECOND = 2'd2
  } fmc_unlock_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_IDREAD  = 8'h90;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_BULK    = 8'h10;
  localparam logic [7:0] OP_SECTOR  = 8'h30;

  // Command byte to command code; only reset is recognised without the prefix.
  function automatic fmc_cmd_e decode_cmd(input logic [7:0] byte_in, input logic prefixed);
    fmc_cmd_e c;
    c = CMD_NONE;
    if (byte_in == OP_RESET) c = CMD_RESET;
    else if (prefixed) begin
      case (byte_in)
        OP_IDREAD:  c = CMD_IDREAD;
        OP_PROGRAM: c = CMD_PROG_ARM;
        OP_BULK:    c = CMD_BULK;
        OP_SECTOR:  c = CMD_SECTOR;
        default:    c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

  // Modes in which the array is working on an operation.
  function automatic logic is_active_op(input fmc_mode_e m);
    return (m == MODE_PROGRAM) || (m == MODE_BULK_ERASE) || (m == MODE_SECTOR_ERASE);
  endfunction

endpackage

// File: rtl/fmc_unlock_decoder.sv
module fmc_unlock_decoder
  import fmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR2 = 'hAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_stb,
  output fmc_cmd_e          cmd_code
);

  localparam logic [DATA_W-1:0] KEY1_W = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] KEY2_W = DATA_W'(KEY_SECOND);

  fmc_unlock_e state_q, state_d;
  logic        upper_clear;
  logic        hit_first;
  logic        hit_second;
  logic        take;
  fmc_cmd_e    code_w;

  assign upper_clear = ((wr_data >> 8) == '0);
  assign hit_first   = (wr_addr == UNLOCK_ADDR1) && (wr_data == KEY1_W);
  assign hit_second  = (wr_addr == UNLOCK_ADDR2) && (wr_data == KEY2_W);
  assign take        = wr_stb && !flush;

  always_comb begin
    code_w = CMD_NONE;
    if (take && upper_clear) begin
      if (state_q == UNL_SECOND)
        code_w = decode_cmd(wr_data[7:0], 1'b1);
      else if (state_q == UNL_IDLE && !hit_first)
        code_w = decode_cmd(wr_data[7:0], 1'b0);
    end
  end

  assign cmd_code = code_w;
  assign cmd_stb  = (code_w != CMD_NONE);

  always_comb begin
    state_d = state_q;
    if (flush) state_d = UNL_IDLE;
    else if (wr_stb) begin
      case (state_q)
        UNL_IDLE:   state_d = hit_first  ? UNL_FIRST  : UNL_IDLE;
        UNL_FIRST:  state_d = hit_second ? UNL_SECOND : UNL_IDLE;
        default:    state_d = UNL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= UNL_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fmc_recover_timer.sv
module fmc_recover_timer #(
  parameter int CYCLES = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);

  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == LAST) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= LOAD;
    else if (busy)   cnt_q <= cnt_q - LAST;
  end

endmodule

// File: rtl/fmc_mode_fsm.sv
module fmc_mode_fsm
  import fmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hw_rst,
  input  logic      wr_stb,
  input  logic      cmd_stb,
  input  fmc_cmd_e  cmd_code,
  input  logic      arr_done,
  input  logic      arr_fault,
  input  logic      rec_expire,
  output fmc_mode_e mode_q,
  output logic      err_flag_q,
  output logic      prog_armed_q,
  output logic      rec_start
);

  fmc_mode_e mode_d;
  logic      armed_d;
  logic      err_d;
  logic      op_live;
  logic      reset_cmd;

  assign op_live   = is_active_op(mode_q);
  assign reset_cmd = cmd_stb && (cmd_code == CMD_RESET);

  always_comb begin
    mode_d    = mode_q;
    armed_d   = prog_armed_q;
    rec_start = 1'b0;
    if (hw_rst) begin
      armed_d = 1'b0;
      if (op_live || mode_q == MODE_RECOVERING) begin
        mode_d    = MODE_RECOVERING;
        rec_start = 1'b1;
      end else begin
        mode_d = MODE_READ;
      end
    end else if (op_live && arr_fault) begin
      mode_d = MODE_ERROR;
    end else if (op_live && arr_done) begin
      mode_d = MODE_READ;
    end else if (mode_q == MODE_RECOVERING) begin
      if (rec_expire) mode_d = MODE_READ;
    end else if (prog_armed_q && wr_stb) begin
      armed_d = 1'b0;
      mode_d  = MODE_PROGRAM;
    end else if (cmd_stb) begin
      case (mode_q)
        MODE_READ: begin
          case (cmd_code)
            CMD_IDREAD:   mode_d  = MODE_STATUS_ID;
            CMD_PROG_ARM: armed_d = 1'b1;
            CMD_BULK:     mode_d  = MODE_BULK_ERASE;
            CMD_SECTOR:   mode_d  = MODE_SECTOR_ERASE;
            default:      mode_d  = MODE_READ;
          endcase
        end
        MODE_STATUS_ID, MODE_ERROR: begin
          if (reset_cmd) mode_d = MODE_READ;
        end
        MODE_SECTOR_ERASE: begin
          if (reset_cmd) begin
            mode_d    = MODE_RECOVERING;
            rec_start = 1'b1;
          end
        end
        default: mode_d = mode_q;
      endcase
    end
  end

  // Error flag kept as its own set/clear register driven by the events.
  always_comb begin
    err_d = err_flag_q;
    if (hw_rst)                                   err_d = 1'b0;
    else if (op_live && arr_fault)                err_d = 1'b1;
    else if (mode_q == MODE_ERROR && reset_cmd)   err_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_READ;
      prog_armed_q <= 1'b0;
      err_flag_q   <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      prog_armed_q <= armed_d;
      err_flag_q   <= err_d;
    end
  end

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int RECOVER_CYCLES = 3125,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR2 = 'hAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arr_done,
  input  logic              arr_fault,
  output logic [2:0]        mode,
  output logic              dq5,
  output logic              busy
);

  fmc_mode_e mode_q;
  fmc_cmd_e  cmd_code;
  logic      cmd_stb;
  logic      err_flag_q;
  logic      prog_armed_q;
  logic      rec_start;
  logic      rec_busy;
  logic      rec_expire;
  logic      dec_flush;

  // Program data phase, recovery and hardware reset all keep the prefix decoder idle.
  assign dec_flush = hw_rst || rec_busy || (prog_armed_q && wr_stb);

  fmc_unlock_decoder #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .UNLOCK_ADDR1 (UNLOCK_ADDR1),
    .UNLOCK_ADDR2 (UNLOCK_ADDR2)
  ) u_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (dec_flush),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd_stb  (cmd_stb),
    .cmd_code (cmd_code)
  );

  fmc_recover_timer #(
    .CYCLES (RECOVER_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rec_start),
    .busy   (rec_busy),
    .expire (rec_expire)
  );

  fmc_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_rst       (hw_rst),
    .wr_stb       (wr_stb),
    .cmd_stb      (cmd_stb),
    .cmd_code     (cmd_code),
    .arr_done     (arr_done),
    .arr_fault    (arr_fault),
    .rec_expire   (rec_expire),
    .mode_q       (mode_q),
    .err_flag_q   (err_flag_q),
    .prog_armed_q (prog_armed_q),
    .rec_start    (rec_start)
  );

  assign mode = mode_q;
  assign dq5  = err_flag_q;
  assign busy = rec_busy;

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker
  import fmc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hw_rst,
  input logic       arr_done,
  input logic       arr_fault,
  input logic [2:0] mode,
  input logic       dq5,
  input logic       busy,
  input logic       cmd_stb,
  input fmc_cmd_e   cmd_code
);

  logic reset_cmd;
  logic quiet;
  assign reset_cmd = cmd_stb && (cmd_code == CMD_RESET);
  assign quiet     = !hw_rst && !arr_done && !arr_fault;

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7);

  assert_busy_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (mode == 3'd6));

  assert_flag_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq5 == (mode == 3'd5));

  assert_reset_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3) && reset_cmd && quiet) |=> $stable(mode));

  assert_sector_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && reset_cmd && quiet) |=> (mode == 3'd6 && busy));

  assert_no_cmd_recovering_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_stb);

  assert_fault_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3 || mode == 3'd4) && arr_fault && !hw_rst) |=> (mode == 3'd5 && dq5));

  assert_error_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !reset_cmd && !hw_rst) |=> (mode == 3'd5));

  assert_hw_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst && (mode == 3'd2 || mode == 3'd3 || mode == 3'd4 || mode == 3'd6)) |=> (mode == 3'd6));

  assert_hw_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst && (mode == 3'd0 || mode == 3'd1 || mode == 3'd5)) |=> (mode == 3'd0));

endmodule

bind flash_mode_ctrl fmc_checker u_fmc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_rst    (hw_rst),
  .arr_done  (arr_done),
  .arr_fault (arr_fault),
  .mode      (mode),
  .dq5       (dq5),
  .busy      (busy),
  .cmd_stb   (cmd_stb),
  .cmd_code  (cmd_code)
);

// File: tb/flash_mode_ctrl_test.sv
module flash_mode_ctrl_test;

  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int REC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_rst = 1'b0;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          arr_done = 1'b0;
  logic          arr_fault = 1'b0;
  logic [2:0]    mode;
  logic          dq5;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECOVER_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .arr_done(arr_done),
    .arr_fault(arr_fault), .mode(mode), .dq5(dq5), .busy(busy)
  );

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    report();
  end

  task automatic check_mode(input logic [2:0] exp, input string tag);
    logic ef, eb;
    ef = (exp == 3'd5);
    eb = (exp == 3'd6);
    checks++;
    if (mode !== exp || dq5 !== ef || busy !== eb) begin
      errors++;
      $display("FAIL %s: actual mode=%0d dq5=%0b busy=%0b expected mode=%0d dq5=%0b busy=%0b",
               tag, mode, dq5, busy, exp, ef, eb);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One stimulus cycle; returns at the falling edge after the capturing rising edge.
  task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic dn, input logic f, input logic h);
    @(negedge clk);
    wr_stb = w; wr_addr = a; wr_data = d; arr_done = dn; arr_fault = f; hw_rst = h;
    @(negedge clk);
    wr_stb = 0; arr_done = 0; arr_fault = 0; hw_rst = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic prefix;
    wr(12'h555, 8'hAA);
    wr(12'hAAA, 8'h55);
  endtask

  task automatic go_read;
    while (busy) @(negedge clk);
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    wr(12'h000, 8'hF0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic enter(input int m);
    go_read();
    case (m)
      1: begin prefix(); wr(12'h000, 8'h90); end
      2: begin prefix(); wr(12'h000, 8'hA0); wr(12'h123, 8'h5A); end
      3: begin prefix(); wr(12'h000, 8'h10); end
      4: begin prefix(); wr(12'h000, 8'h30); end
      5: begin prefix(); wr(12'h000, 8'h30); cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0); end
      default: ;
    endcase
  endtask

  // Counts falling edges with busy high, starting at the current one.
  task automatic count_recovery(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [2:0] exp_after_reset(input int m);
    case (m)
      2: return 3'd2;
      3: return 3'd3;
      4: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] exp_prefixed(input logic [7:0] d);
    if (d == 8'h90) return 3'd1;
    if (d == 8'h10) return 3'd3;
    if (d == 8'h30) return 3'd4;
    return 3'd0;
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_mode(3'd0, "R1 reset state");

    // R2 / R3: every command byte after the prefix
    for (int d = 0; d < 256; d++) begin
      go_read();
      prefix();
      wr(12'h000, d[7:0]);
      check_mode(exp_prefixed(d[7:0]), $sformatf("R2 prefixed byte %02h", d));
      if (d == 8'hA0) begin
        wr(12'h7, 8'hF0);
        check_mode(3'd2, "R3 armed write with F0 enters program");
      end
    end

    // R4 / R3: bare bytes in read mode
    go_read();
    for (int d = 0; d < 256; d++) begin
      wr(12'h000, d[7:0]);
      check_mode(3'd0, $sformatf("R4 bare byte %02h", d));
      wr(12'h010, 8'h5A);
      check_mode(3'd0, $sformatf("R3 no arming after bare %02h", d));
    end

    // R5: mismatched second unlock cycle
    for (int d = 0; d < 256; d++) begin
      if (d != 8'h55) begin
        wr(12'h555, 8'hAA);
        wr(12'hAAA, d[7:0]);
        wr(12'h000, 8'h90);
        check_mode(3'd0, $sformatf("R5 wrong key %02h", d));
      end
    end
    wr(12'h555, 8'hAA);
    wr(12'h554, 8'h55);
    wr(12'h000, 8'h90);
    check_mode(3'd0, "R5 wrong second address");
    enter(1);
    wr(12'h555, 8'hAA);
    wr(12'hAAA, 8'hF0);
    check_mode(3'd1, "R5 F0 in second slot is no reset");

    // R6: status/ID mode holds
    enter(1);
    prefix(); wr(12'h000, 8'h10);
    check_mode(3'd1, "R6 prefixed 10h ignored");
    prefix(); wr(12'h000, 8'hA0);
    wr(12'h040, 8'h5A);
    check_mode(3'd1, "R6 prefixed A0h ignored");

    // R4 R7 R8 R11: reset command in every mode, bare and prefixed
    for (int m = 0; m < 6; m++) begin
      for (int form = 0; form < 2; form++) begin
        enter(m);
        if (form == 1) prefix();
        wr(12'h000, 8'hF0);
        check_mode(exp_after_reset(m), $sformatf("R4 R7 R8 R11 reset form %0d in mode %0d", form, m));
        if (m == 4) begin
          count_recovery(n);
          check_int(n, REC, "R8 recovery length");
          check_mode(3'd0, "R8 read after recovery");
        end
      end
    end

    // R9: writes discarded while recovering
    enter(4);
    wr(12'h000, 8'hF0);
    prefix();
    wr(12'h000, 8'h90);
    check_mode(3'd6, "R9 writes during recovery");
    while (busy) @(negedge clk);
    wr(12'h000, 8'h90);
    check_mode(3'd0, "R9 no prefix left after recovery");

    // R10: completion and failure, including same-cycle collisions
    enter(2);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
    check_mode(3'd5, "R10 program fault");
    enter(3);
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    check_mode(3'd0, "R10 bulk done");
    enter(4);
    cyc(1'b1, 12'h000, 8'hF0, 1'b1, 1'b0, 1'b0);
    check_mode(3'd0, "R10 sector done beats reset command");
    enter(4);
    cyc(1'b1, 12'h000, 8'hF0, 1'b0, 1'b1, 1'b0);
    check_mode(3'd5, "R10 sector fault beats reset command");
    enter(2);
    cyc(1'b0, '0, '0, 1'b1, 1'b1, 1'b0);
    check_mode(3'd5, "R10 fault beats done");

    // R11 / R13: error mode holds
    enter(5);
    prefix(); wr(12'h000, 8'h90);
    check_mode(3'd5, "R11 error holds on command");
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    check_mode(3'd5, "R13 done ignored in error");

    // R13: array pulses outside operations
    enter(0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
    check_mode(3'd0, "R13 fault ignored in read");
    enter(1);
    cyc(1'b0, '0, '0, 1'b1, 1'b1, 1'b0);
    check_mode(3'd1, "R13 pulses ignored in status");

    // R12: hardware reset
    enter(2);
    cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
    check_mode(3'd6, "R12 hw reset beats done in program");
    count_recovery(n);
    check_int(n, REC, "R12 recovery length after hw reset");
    enter(4);
    wr(12'h000, 8'hF0);
    repeat (8) @(negedge clk);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    count_recovery(n);
    check_int(n, REC, "R12 hw reset restarts recovery");
    enter(1);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    check_mode(3'd0, "R12 hw reset in status");
    enter(5);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    check_mode(3'd0, "R12 hw reset in error");
    enter(0);
    prefix();
    cyc(1'b1, 12'h000, 8'h90, 1'b0, 1'b0, 1'b1);
    check_mode(3'd0, "R12 hw reset beats command");
    wr(12'h000, 8'h90);
    check_mode(3'd0, "R12 decoder cleared");
    prefix(); wr(12'h000, 8'hA0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    wr(12'h020, 8'h5A);
    check_mode(3'd0, "R12 armed program cleared");

    report();
  end

endmodule